// File: doc/BRIEF.md
# Write-Only I2C Control-Register Target

This block is a receive-only I2C target that runs on a fast system clock. It oversamples the SCL and SDA lines through a synchronizer and finds START and STOP conditions and SCL edges on the synchronized copies. It answers one fixed device address with the direction bit at write. It then loads a small bank of 8-bit control registers and acknowledges each byte by pulling SDA low. SDA is open-drain, so the block never drives a high level. It only asserts an output-enable that pulls the line low.

After the device address, the first byte is a register pointer. Every byte after that goes to the register the pointer selects, and the pointer then advances by one. A controller can therefore fill several registers in one transfer. Pointers outside the register range are still acknowledged, but their data is dropped.

The register at pointer 1 is also decoded into a registered source selection and a signed gain in dB. Codes that have no meaning leave the decoded outputs as they were. All registers and outputs come out of reset at zero, which means muted and 0 dB.

Top module: `ctl_i2c_target`

## Requirements
- R1: After reset every register byte is 0x00, `src_sel` is 0 (mute), `gain_db` is 0 and `sda_oe` is low.
- R2: An address byte of 0xEE (7-bit address 0x77, direction bit 0) is acknowledged by holding SDA low during the ninth SCL pulse. Any other address byte is not acknowledged, including 0xEF with the read bit set. After a rejected address, the rest of the transfer up to the next START is ignored.
- R3: After an accepted address, the pointer byte and every data byte are acknowledged. `sda_oe` is high only from the SCL fall after the eighth bit until the SCL fall that ends the ninth pulse, and at no other time.
- R4: A START or STOP in the middle of a byte discards the partial byte. A START opens a new address phase, and a following complete transfer is received correctly.
- R5: Bytes arrive MSB first and are sampled on the rising edge of SCL. A data byte is stored in register k, for k from 1 to 5, when the pointer equals k. Register k occupies `regs_flat[8k-1:8k-8]`.
- R6: After each data byte the pointer increments by one, so a burst fills consecutive registers until STOP. When the pointer steps from 5 to 6, the data is dropped and the earlier registers are kept.
- R7: A pointer outside 1..5 (for example 0x00 or 0x07) is acknowledged, and the data bytes written through it change no register. A pointer of 0x00 does reach register 1 after one increment.
- R8: Bits [2:0] of register 1 select the source: 000 gives `src_sel`=0 (mute), 001 gives 1 (A), 010 gives 2 (B) and 011 gives 3 (C).
- R9: Bits [5:3] of register 1 set `gain_db` as a two's-complement number: 011 gives -6, 010 gives -4, 000 gives 0, 110 gives +4 and 111 gives +6.
- R10: A source code of 100..111 leaves `src_sel` unchanged, and a gain code of 001, 100 or 101 leaves `gain_db` unchanged. The raw byte is still stored in register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired) |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| regs_flat | output | NUM_REGS*8 (40) | Register contents; register k in byte k-1 |
| src_sel | output | 2 | Decoded source: 0 mute, 1 A, 2 B, 3 C |
| gain_db | output | 4 | Decoded gain in dB, signed |

## Verification
The commit of a data byte and the pointer increment happen in the same clock. The write must use the pointer value from before the step, and the next byte must see the stepped value. A six-byte burst that starts at pointer 1 provokes this collision on every byte. So does a burst that starts at pointer 0, where the first byte is dropped and the second must reach register 1. A behavioural model in the bench advances its own pointer only after each acknowledge clock and compares every register byte and decoded output on each clock edge. Any byte that lands in the wrong register therefore shows as a miscompare.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_BITS = 2'd1,
    RX_ACK  = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_PTR  = 2'd1,
    KIND_DATA = 2'd2
  } byte_kind_e;

  typedef struct packed {
    logic              ok;
    logic signed [3:0] db;
  } gain_dec_t;

  localparam logic [1:0] SRC_MUTE = 2'd0;

  function automatic gain_dec_t gain_lookup(input logic [2:0] code);
    gain_dec_t r;
    r.ok = 1'b1;
    r.db = 4'sd0;
    case (code)
      3'b011:  r.db = -4'sd6;
      3'b010:  r.db = -4'sd4;
      3'b000:  r.db = 4'sd0;
      3'b110:  r.db = 4'sd4;
      3'b111:  r.db = 4'sd6;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d, sda_d, scl_s;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_pipe[0] <= 1'b1;
            sda_pipe[0] <= 1'b1;
          end else begin
            scl_pipe[0] <= scl_i;
            sda_pipe[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_pipe[g] <= 1'b1;
            sda_pipe[g] <= 1'b1;
          end else begin
            scl_pipe[g] <= scl_pipe[g-1];
            sda_pipe[g] <= sda_pipe[g-1];
          end
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h77,
  parameter int         PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

  rx_state_e        st;
  byte_kind_e       kind;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic             byte_done;

  assign byte_done = (st == RX_BITS) && scl_fall && (bit_cnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= RX_IDLE;
      kind    <= KIND_ADDR;
      bit_cnt <= '0;
      shreg   <= '0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st      <= RX_BITS;
        kind    <= KIND_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        st      <= RX_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          RX_BITS: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              bit_cnt <= '0;
              case (kind)
                KIND_ADDR: begin
                  if (shreg == ADDR_BYTE) begin
                    kind   <= KIND_PTR;
                    sda_oe <= 1'b1;
                    st     <= RX_ACK;
                  end else begin
                    st <= RX_SKIP;
                  end
                end
                KIND_PTR: begin
                  ptr    <= PTR_W'(shreg);
                  kind   <= KIND_DATA;
                  sda_oe <= 1'b1;
                  st     <= RX_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr + 1'b1;
                  sda_oe  <= 1'b1;
                  st      <= RX_ACK;
                end
              endcase
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= RX_BITS;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctlreg_pkg::*;
#(
  parameter int NUM_REGS  = 5,
  parameter int FIRST_SUB = 1,
  parameter int PTR_W     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [PTR_W-1:0]        wr_addr,
  input  logic [7:0]              wr_data,
  output logic [NUM_REGS*8-1:0]   regs_flat,
  output logic [1:0]              src_sel,
  output logic signed [3:0]       gain_db
);
  localparam logic [PTR_W-1:0] DECODE_SUB = PTR_W'(FIRST_SUB);

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [PTR_W-1:0] MY_SUB = PTR_W'(FIRST_SUB + g);
      logic [7:0] r;
      always_ff @(posedge clk) begin
        if (rst)
          r <= '0;
        else if (wr_en && wr_addr == MY_SUB)
          r <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = r;
    end
  endgenerate

  gain_dec_t gdec;
  logic      sel_hit;

  assign gdec    = gain_lookup(wr_data[5:3]);
  assign sel_hit = wr_en && (wr_addr == DECODE_SUB);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel <= SRC_MUTE;
      gain_db <= 4'sd0;
    end else if (sel_hit) begin
      if (!wr_data[2]) src_sel <= wr_data[1:0];
      if (gdec.ok)     gain_db <= gdec.db;
    end
  end
endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h77,
  parameter int         NUM_REGS    = 5,
  parameter int         FIRST_SUB   = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_flat,
  output logic [1:0]            src_sel,
  output logic signed [3:0]     gain_db
);
  localparam int PTR_W = 8;

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr;
  logic [7:0]       wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rx_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ctl_reg_bank #(.NUM_REGS(NUM_REGS), .FIRST_SUB(FIRST_SUB), .PTR_W(PTR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .regs_flat(regs_flat), .src_sel(src_sel), .gain_db(gain_db)
  );
endmodule

// File: rtl/ctl_i2c_target_chk.sv
module ctl_i2c_target_chk #(
  parameter int NUM_REGS = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] regs_flat,
  input logic [1:0]            src_sel,
  input logic signed [3:0]     gain_db
);
  logic [NUM_REGS*8-1:0] prev_regs;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk) begin
    if (rst) prev_regs <= '0;
    else     prev_regs <= regs_flat;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_chg
      assign chg[g] = (regs_flat[g*8 +: 8] != prev_regs[g*8 +: 8]);
    end
  endgenerate

  // R1: reset clears everything
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (regs_flat == '0 && src_sel == 2'd0 && gain_db == 4'sd0 && !sda_oe));

  // R3: acknowledge drive only changes while SCL is low
  a_r3_oe_rise_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);
  a_r3_oe_fall_scl_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_i);

  // R5: one byte write per cycle at most
  a_r5_single_byte_write: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);

  // R9: gain is always one of the legal values
  a_r9_gain_legal: assert property (@(posedge clk) disable iff (rst)
    (gain_db == -4'sd6 || gain_db == -4'sd4 || gain_db == 4'sd0 ||
     gain_db == 4'sd4 || gain_db == 4'sd6));

  // R10: decoded outputs move only together with register 1
  a_r10_decode_follows_reg1: assert property (@(posedge clk) disable iff (rst)
    !$stable({src_sel, gain_db}) |-> !$stable(regs_flat[7:0]));
endmodule

bind ctl_i2c_target ctl_i2c_target_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .regs_flat(regs_flat), .src_sel(src_sel), .gain_db(gain_db)
);

// File: tb/ctl_i2c_target_tb_top.sv
module ctl_i2c_target_tb_top;
  localparam int NREG = 5;
  localparam int Q    = 8;
  typedef logic [7:0] byte_q_t[$];

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_drv = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_flat;
  logic [1:0] src_sel;
  logic signed [3:0] gain_db;
  logic sda_line;
  assign sda_line = sda_drv & ~sda_oe;

  always #4 clk = ~clk;

  ctl_i2c_target dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .regs_flat(regs_flat), .src_sel(src_sel), .gain_db(gain_db)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [7:0] m_reg [NREG];
  int m_src = 0, m_gain = 0;
  bit cmp_en = 0, in_ack = 0;
  string phase = "R1";
  int bstate = 0;
  bit addressed = 0;
  logic [7:0] cur_sub = 0;

  task automatic fail(input string req, input string what, input int act, input int exp);
    miscompares++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  always @(negedge clk) begin
    if (!rst && cmp_en) begin
      for (int k = 0; k < NREG; k++) begin
        vectors++;
        if (regs_flat[k*8 +: 8] !== m_reg[k])
          fail({"R5/", phase}, $sformatf("reg%0d", k+1), int'(regs_flat[k*8 +: 8]), int'(m_reg[k]));
      end
      vectors++;
      if (int'(src_sel) != m_src) fail({"R8/", phase}, "src_sel", int'(src_sel), m_src);
      vectors++;
      if (int'(gain_db) != m_gain) fail({"R9/", phase}, "gain_db", int'(gain_db), m_gain);
    end
    if (!rst && !in_ack) begin
      vectors++;
      if (sda_oe !== 1'b0) fail("R3", "sda_oe outside ack", int'(sda_oe), 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog %s actual=%0d expected=%0d", phase, cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic wait_q(input int n);
    repeat (n*Q) @(posedge clk);
    #1;
  endtask

  function automatic void model_write(input logic [7:0] sub, input logic [7:0] d);
    if (sub >= 8'd1 && sub <= 8'(NREG)) begin
      m_reg[int'(sub) - 1] = d;
      if (sub == 8'd1) begin
        case (d[2:0])
          3'b000: m_src = 0;
          3'b001: m_src = 1;
          3'b010: m_src = 2;
          3'b011: m_src = 3;
          default: ;
        endcase
        case (d[5:3])
          3'b011: m_gain = -6;
          3'b010: m_gain = -4;
          3'b000: m_gain = 0;
          3'b110: m_gain = 4;
          3'b111: m_gain = 6;
          default: ;
        endcase
      end
    end
  endfunction

  task automatic bus_start();
    sda_drv = 1; wait_q(1);
    scl = 1;     wait_q(1);
    sda_drv = 0; wait_q(1);
    scl = 0;     wait_q(1);
    bstate = 0; addressed = 0;
  endtask

  task automatic bus_stop();
    sda_drv = 0; wait_q(1);
    scl = 1;     wait_q(1);
    sda_drv = 1; wait_q(1);
  endtask

  task automatic send_partial(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wait_q(1);
      scl = 1;        wait_q(2);
      scl = 0;        wait_q(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit exp_ack, is_data;
    is_data = addressed && bstate == 2;
    exp_ack = (bstate == 0) ? (b == 8'hEE) : addressed;
    if (is_data) cmp_en = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wait_q(1);
      scl = 1;        wait_q(2);
      if (i == 0) in_ack = 1;
      scl = 0;        wait_q(1);
    end
    sda_drv = 1; wait_q(1);
    scl = 1;     wait_q(1);
    vectors++;
    if (sda_line !== !exp_ack)
      fail((bstate == 0) ? {"R2/", phase} : {"R3/", phase},
           $sformatf("ack line for byte %02h", b), int'(sda_line), int'(!exp_ack));
    wait_q(1);
    scl = 0; wait_q(1);
    in_ack = 0;
    if (bstate == 0) begin
      addressed = exp_ack; bstate = 1;
    end else if (bstate == 1) begin
      cur_sub = b; bstate = 2;
    end else if (addressed) begin
      model_write(cur_sub, b);
      cur_sub = cur_sub + 8'd1;
    end
    cmp_en = 1;
  endtask

  task automatic tx(input logic [7:0] dev, input logic [7:0] sub, input byte_q_t d);
    bus_start();
    send_byte(dev);
    send_byte(sub);
    foreach (d[i]) send_byte(d[i]);
    bus_stop();
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) m_reg[k] = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    vectors++;
    if (regs_flat !== '0) fail("R1", "regs_flat", int'(regs_flat[31:0]), 0);
    vectors++;
    if (src_sel !== 2'd0) fail("R1", "src_sel", int'(src_sel), 0);
    vectors++;
    if (gain_db !== 4'sd0) fail("R1", "gain_db", int'(gain_db), 0);
    vectors++;
    if (sda_oe !== 1'b0) fail("R1", "sda_oe", int'(sda_oe), 0);
    cmp_en = 1;
    wait_q(2);

    phase = "R8";  tx(8'hEE, 8'h01, '{8'h01});
    phase = "R6";  tx(8'hEE, 8'h01, '{8'h1A, 8'h40, 8'h33, 8'h44, 8'h55, 8'h66});
    phase = "R2";  tx(8'hEC, 8'h02, '{8'h99});
    phase = "R2";  tx(8'hEF, 8'h03, '{8'h98});
    phase = "R7";  tx(8'hEE, 8'h07, '{8'h97, 8'h96});
    phase = "R7";  tx(8'hEE, 8'h00, '{8'h77, 8'h31});
    phase = "R10"; tx(8'hEE, 8'h01, '{8'h0D});
    phase = "R9";  tx(8'hEE, 8'h01, '{8'h3B});
    phase = "R9";  tx(8'hEE, 8'h01, '{8'h12});
    phase = "R8";  tx(8'hEE, 8'h01, '{8'h00});
    phase = "R10"; tx(8'hEE, 8'h01, '{8'h23});
    phase = "R10"; tx(8'hEE, 8'h01, '{8'h2C});
    phase = "R9";  tx(8'hEE, 8'h01, '{8'h31, 8'h5A});

    phase = "R4";
    bus_start(); send_byte(8'hEE); send_byte(8'h02); send_partial(8'h3C, 4);
    tx(8'hEE, 8'h02, '{8'hA5});
    bus_start(); send_byte(8'hEE); send_byte(8'h03); send_partial(8'hF0, 5);
    bus_stop();
    wait_q(4);
    tx(8'hEE, 8'h04, '{8'hC3});

    wait_q(4);
    summary();
    $finish;
  end
endmodule